// File: doc/BRIEF.md
# Configurable Three-Input Logic Cell

This block is one programmable logic cell of a fine-grained fabric. A configuration word, written through a small register interface with a one-cycle strobe, sets three things. It chooses which of the three inputs are inverted. It chooses a mode: a combinational function given by an 8-entry truth table, a level-sensitive latch, or an edge-triggered flip-flop. It also chooses whether the storage control input clears or sets the stored value. The cell drives a single output.

The cell can realise any Boolean function of its three inputs except odd or even parity. A parity function cannot be built from one cell, and inverting an input only turns one parity function into the other. Both parity tables are refused when loaded, and so is the reserved mode code. A refused load leaves the old configuration in place and raises an error flag for one cycle. Storage modes run on the system clock. The gate or storage clock is an ordinary input that is sampled on each clock edge, and the clear/set control overrides the cell combinationally.

Top module: `logic_tile_cell`

## Requirements
- R1: After synchronous active-low reset the cell is in combinational mode with an all-zero truth table and no inversion, so `cell_out` is 0 and `cfg_err` is 0.
- R2: The configuration word is laid out as bits [2:0] inversion mask, bits [4:3] mode (00 combinational, 01 latch, 10 flip-flop, 11 reserved), bit [5] clear/set select (0 clears, 1 sets), and bits [13:6] truth table. In combinational mode `cell_out` equals truth-table bit number {x2,x1,x0}, where x = `din` XOR mask, in the same cycle.
- R3: Each mask bit inverts only its own input, both in the combinational function and in the storage roles.
- R4: A load whose truth table is 8'h96 or 8'h69 (a parity function) is refused whatever its mode. The active configuration is unchanged and `cfg_err` is 1 during the next cycle only.
- R5: A load with mode 11 is refused in the same way as in R4.
- R6: A legal load takes effect from the clock edge that samples the strobe, leaves `cfg_err` at 0, and clears the stored value to 0.
- R7: In latch mode, where x0 is the data and x1 the gate, `cell_out` follows x0 in the same cycle while x1 is 1, and holds the last value it had while x1 is 0.
- R8: In flip-flop mode a rising edge of x1 is seen at a clock edge where x1 is 1 and x1 was 0 at the clock edge before. At that clock edge the cell stores the x0 value sampled at the previous clock edge, and `cell_out` shows it after that clock edge. Otherwise the output does not change.
- R9: In either storage mode, x2 = 1 forces `cell_out` to the clear/set select value in the same cycle, whatever the gate does. The stored value takes that value too and keeps it after x2 falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also samples the gate input in storage modes |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_valid | input | 1 | One-cycle strobe that loads `cfg_word` |
| cfg_word | input | 14 | Configuration word (layout in R2) |
| din | input | 3 | Logic inputs; in storage modes bit 0 is data, bit 1 is gate, bit 2 is clear/set |
| cell_out | output | 1 | Cell output |
| cfg_err | output | 1 | One-cycle pulse after a refused load |

## Verification
Two functions can fall in the same cycle. The clear/set override can arrive on the same edge as a rising gate in flip-flop mode, or while the latch gate is open. A configuration load can also coincide with active storage inputs. The bench provokes the first case by raising the gate and the control together, and the second by writing a new configuration while the gate toggles. A behavioural model rules on each case every cycle: the override wins over the edge, and a legal load wins over storage updates, leaving the stored value at 0.

// File: rtl/tile_pkg.sv
// Package: shared widths, configuration layout and legality check for the
// three-input logic cell. Assumes exactly three logic inputs.
package tile_pkg;

    localparam int unsigned N_IN  = 3;
    localparam int unsigned TT_W  = 1 << N_IN;
    localparam int unsigned CFG_W = TT_W + 1 + 2 + N_IN;

    // Role of each (inverted) input while the cell stores a value.
    localparam int unsigned ROLE_DATA = 0;
    localparam int unsigned ROLE_GATE = 1;
    localparam int unsigned ROLE_CTRL = 2;

    typedef enum logic [1:0] {
        MODE_COMB  = 2'b00,
        MODE_LATCH = 2'b01,
        MODE_FLOP  = 2'b10,
        MODE_RSVD  = 2'b11
    } tile_mode_e;

    typedef struct packed {
        logic [TT_W-1:0] table_bits;
        logic            set_sel;
        tile_mode_e      mode;
        logic [N_IN-1:0] inv;
    } tile_cfg_t;

    // Builds the odd-parity truth table and tests for it or its complement.
    function automatic logic is_parity(input logic [TT_W-1:0] tbl);
        logic [TT_W-1:0] par;
        for (int i = 0; i < TT_W; i++) begin
            par[i] = ^(i[N_IN-1:0]);
        end
        return (tbl == par) || (tbl == ~par);
    endfunction

    // A configuration may be stored only when realisable by a single cell.
    function automatic logic cfg_legal(input tile_cfg_t c);
        return !is_parity(c.table_bits) && (c.mode != MODE_RSVD);
    endfunction

endpackage

// File: rtl/tile_cfg_reg.sv
// Configuration register: accepts a word on a strobe, refuses parity
// functions and the reserved mode, and pulses an error for one cycle.
// Assumes the strobe is synchronous to clk.
module tile_cfg_reg
    import tile_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [CFG_W-1:0] cfg_word,
    output tile_cfg_t        cfg,
    output logic             load_ok,
    output logic             cfg_err
);

    tile_cfg_t req;
    logic      legal;

    assign req     = tile_cfg_t'(cfg_word);
    assign legal   = cfg_legal(req);
    assign load_ok = cfg_valid && legal;

    // Holds the active configuration; only legal words replace it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (load_ok) begin
            cfg <= req;
        end
    end

    // Flags a refused load during the cycle after its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= cfg_valid && !legal;
        end
    end

    assert_parity_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && is_parity(cfg_word[CFG_W-1 -: TT_W])) |=> ($stable(cfg) && cfg_err));

    assert_reserved_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && (cfg_word[4:3] == 2'b11)) |=> ($stable(cfg) && cfg_err));

    assert_legal_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_ok |=> ((cfg == $past(req)) && !cfg_err));

endmodule

// File: rtl/tile_polarity.sv
// Input polarity stage: each input passes through or is inverted by its own
// mask bit. Purely combinational.
module tile_polarity #(
    parameter int unsigned WIDTH = 3
) (
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] inv,
    output logic [WIDTH-1:0] x
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pol
        // One XOR per input so the mask bits stay independent.
        assign x[i] = din[i] ^ inv[i];
    end

endmodule

// File: rtl/tile_lut.sv
// Truth-table function: selects one table bit with the inverted inputs as
// index. Assumes the table holds 2**WIDTH entries.
module tile_lut #(
    parameter int unsigned WIDTH = 3,
    localparam int unsigned ENTRIES = 1 << WIDTH
) (
    input  logic [ENTRIES-1:0] table_bits,
    input  logic [WIDTH-1:0]   x,
    output logic               y
);

    // Indexes the table with the input vector.
    always_comb begin
        y = table_bits[x];
    end

endmodule

// File: rtl/tile_storage.sv
// Storage stage: a master/slave pair on the system clock. Latch mode uses
// the slave alone; flip-flop mode moves master to slave on a sampled rising
// gate. The control input overrides both combinationally. Assumes the gate
// changes no faster than clk can sample it.
module tile_storage (
    input  logic clk,
    input  logic rst_n,
    input  logic is_latch,
    input  logic is_flop,
    input  logic set_sel,
    input  logic d,
    input  logic g,
    input  logic c,
    input  logic clear_state,
    output logic q
);

    logic master, slave, gate_q;
    logic latch_o, flop_o, rise;

    assign rise = g && !gate_q;

    // Output value of each storage flavour, with the control override.
    always_comb begin
        latch_o = c ? set_sel : (g ? d : slave);
        flop_o  = c ? set_sel : slave;
        q       = is_latch ? latch_o : flop_o;
    end

    // Remembers the gate level at the last clock edge for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else begin
            gate_q <= g;
        end
    end

    // Master stage: open while the gate is low in flip-flop mode.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_state) begin
            master <= 1'b0;
        end else if (is_flop) begin
            if (c) begin
                master <= set_sel;
            end else if (!g) begin
                master <= d;
            end
        end
    end

    // Slave stage: holds the latch value or takes the master on a rise.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_state) begin
            slave <= 1'b0;
        end else if (is_latch) begin
            slave <= latch_o;
        end else if (is_flop) begin
            if (c) begin
                slave <= set_sel;
            end else if (rise) begin
                slave <= master;
            end
        end
    end

    assert_override_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((is_latch || is_flop) && c) |-> (q == set_sel));

    assert_latch_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (is_latch && g && !c) |-> (q == d));

    assert_flop_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_flop && !c && !rise && !clear_state) |=> (slave == $past(slave)));

endmodule

// File: rtl/logic_tile_cell.sv
// Top of the configurable three-input cell: configuration register,
// polarity stage, truth-table function and storage stage, with the output
// chosen by the active mode. Assumes single-clock operation.
module logic_tile_cell
    import tile_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_valid,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic [N_IN-1:0]  din,
    output logic             cell_out,
    output logic             cfg_err
);

    tile_cfg_t       cfg;
    logic            load_ok;
    logic [N_IN-1:0] x;
    logic            lut_y, st_q;

    tile_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_valid(cfg_valid),
        .cfg_word (cfg_word),
        .cfg      (cfg),
        .load_ok  (load_ok),
        .cfg_err  (cfg_err)
    );

    tile_polarity #(.WIDTH(N_IN)) u_pol (
        .din(din),
        .inv(cfg.inv),
        .x  (x)
    );

    tile_lut #(.WIDTH(N_IN)) u_lut (
        .table_bits(cfg.table_bits),
        .x         (x),
        .y         (lut_y)
    );

    tile_storage u_st (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_latch   (cfg.mode == MODE_LATCH),
        .is_flop    (cfg.mode == MODE_FLOP),
        .set_sel    (cfg.set_sel),
        .d          (x[ROLE_DATA]),
        .g          (x[ROLE_GATE]),
        .c          (x[ROLE_CTRL]),
        .clear_state(load_ok),
        .q          (st_q)
    );

    // Picks the function result or the stored value by mode.
    always_comb begin
        cell_out = (cfg.mode == MODE_COMB) ? lut_y : st_q;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!cell_out && !cfg_err));

endmodule

// File: tb/logic_tile_cell_tb.sv
module logic_tile_cell_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [13:0] cfg_word = '0;
    logic [2:0]  din = '0;
    logic        cell_out, cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    logic_tile_cell u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
        .din(din), .cell_out(cell_out), .cfg_err(cfg_err)
    );

    // Behavioural reference state
    bit       m_known = 0;
    bit [7:0] m_tt;
    bit       m_sel;
    bit [1:0] m_mode;
    bit [2:0] m_inv;
    bit       m_master, m_slave, m_gq, m_err;

    function automatic bit [13:0] mkw(bit [7:0] tt, bit sel, bit [1:0] mode, bit [2:0] inv);
        return {tt, sel, mode, inv};
    endfunction

    function automatic bit m_out(bit [2:0] di);
        bit [2:0] xx = di ^ m_inv;
        case (m_mode)
            2'd0:    return m_tt[xx];
            2'd1:    return xx[2] ? m_sel : (xx[1] ? xx[0] : m_slave);
            default: return xx[2] ? m_sel : m_slave;
        endcase
    endfunction

    task automatic check(bit act, bit exp, string what, string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic step(bit [2:0] di, bit v, bit [13:0] w, string tag);
        bit ex, bad;
        bit [2:0] xx;
        @(negedge clk);
        din = di; cfg_valid = v; cfg_word = w;
        #1;
        if (m_known) begin
            ex = m_out(di);
            check(cell_out, ex, "cell_out", tag);
            check(cfg_err, m_err, "cfg_err", tag);
        end
        @(posedge clk);
        if (!rst_n) begin
            m_known = 1; m_tt = 0; m_sel = 0; m_mode = 0; m_inv = 0;
            m_master = 0; m_slave = 0; m_gq = 0; m_err = 0;
        end else if (m_known) begin
            xx  = di ^ m_inv;
            bad = v && (w[13:6] == 8'h96 || w[13:6] == 8'h69 || w[4:3] == 2'b11);
            m_gq = xx[1];
            if (v && !bad) begin
                {m_tt, m_sel, m_mode, m_inv} = w;
                m_master = 0; m_slave = 0;
            end else if (m_mode == 2'd1) begin
                m_slave = ex;
            end else if (m_mode == 2'd2) begin
                if (xx[2]) begin
                    m_master = m_sel; m_slave = m_sel;
                end else begin
                    if (xx[1] && !m_gq_prev) m_slave = m_master;
                    if (!xx[1]) m_master = di[0] ^ m_inv[0];
                end
            end
            m_gq_prev = m_gq;
            m_err = bad;
        end
    endtask

    bit m_gq_prev = 0;

    task automatic load(bit [13:0] w, string tag);
        step(3'b000, 1'b1, w, tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) step(3'b111, 1'b0, '0, "R1");
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) step(i[2:0], 1'b0, '0, "R1");

        // R2: combinational AND and majority
        load(mkw(8'h80, 0, 2'd0, 3'b000), "R6");
        for (int i = 0; i < 8; i++) step(i[2:0], 1'b0, '0, "R2");
        load(mkw(8'hE8, 0, 2'd0, 3'b000), "R6");
        for (int i = 0; i < 8; i++) step(i[2:0], 1'b0, '0, "R2");

        // R3: independent inversion
        load(mkw(8'h80, 0, 2'd0, 3'b101), "R6");
        for (int i = 0; i < 8; i++) step(i[2:0], 1'b0, '0, "R3");
        load(mkw(8'hAA, 0, 2'd0, 3'b010), "R6");
        for (int i = 0; i < 8; i++) step(i[2:0], 1'b0, '0, "R3");

        // R4: parity refused, old config kept
        load(mkw(8'h96, 0, 2'd0, 3'b000), "R4");
        for (int i = 0; i < 8; i++) step(i[2:0], 1'b0, '0, "R4");
        load(mkw(8'h69, 0, 2'd1, 3'b000), "R4");
        load(mkw(8'h96, 0, 2'd2, 3'b000), "R4");
        for (int i = 0; i < 8; i++) step(i[2:0], 1'b0, '0, "R4");

        // R5: reserved mode refused
        load(mkw(8'h01, 0, 2'd3, 3'b000), "R5");
        for (int i = 0; i < 8; i++) step(i[2:0], 1'b0, '0, "R5");

        // R7: latch, clear select
        load(mkw(8'h00, 0, 2'd1, 3'b000), "R6");
        step(3'b011, 0, '0, "R7"); step(3'b010, 0, '0, "R7");
        step(3'b011, 0, '0, "R7"); step(3'b001, 0, '0, "R7");
        step(3'b000, 0, '0, "R7"); step(3'b010, 0, '0, "R7");
        step(3'b001, 0, '0, "R7");
        // R9: clear while gate open, then hold
        step(3'b011, 0, '0, "R9"); step(3'b111, 0, '0, "R9");
        step(3'b001, 0, '0, "R9"); step(3'b000, 0, '0, "R9");

        // R9 with R3: set select, control active low at the pin
        load(mkw(8'h00, 1, 2'd1, 3'b100), "R6");
        step(3'b100, 0, '0, "R9"); step(3'b000, 0, '0, "R9");
        step(3'b100, 0, '0, "R9"); step(3'b110, 0, '0, "R9");
        step(3'b100, 0, '0, "R9");

        // R8: flip-flop
        load(mkw(8'h00, 0, 2'd2, 3'b000), "R6");
        step(3'b001, 0, '0, "R8"); step(3'b011, 0, '0, "R8");
        step(3'b010, 0, '0, "R8"); step(3'b000, 0, '0, "R8");
        step(3'b000, 0, '0, "R8"); step(3'b011, 0, '0, "R8");
        step(3'b011, 0, '0, "R8"); step(3'b001, 0, '0, "R8");
        step(3'b001, 0, '0, "R8"); step(3'b010, 0, '0, "R8");
        step(3'b011, 0, '0, "R8");
        // R9: control on the same edge as a rising gate
        load(mkw(8'h00, 1, 2'd2, 3'b000), "R6");
        step(3'b000, 0, '0, "R9"); step(3'b110, 0, '0, "R9");
        step(3'b000, 0, '0, "R9"); step(3'b000, 0, '0, "R9");

        // R6: legal load clears stored value while gate toggles
        load(mkw(8'h00, 1, 2'd2, 3'b000), "R6");
        step(3'b100, 0, '0, "R6"); step(3'b000, 0, '0, "R6");
        step(3'b010, 1, mkw(8'h00, 0, 2'd2, 3'b000), "R6");
        step(3'b000, 0, '0, "R6"); step(3'b000, 0, '0, "R6");

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            bit [13:0] w = 14'($urandom);
            if (($urandom % 4) == 0) w[13:6] = (($urandom % 2) == 0) ? 8'h96 : 8'h69;
            step(3'($urandom), (($urandom % 16) == 0), w, "R6");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule